// File: doc/BRIEF.md
# Programmable Pulse Train Generator with Burst Mode

This block turns a programmed period and high-time into a rectangular pulse train on a single output line. Both values arrive in steps of 0.1 µs. Against the 50 MHz system clock, one step is five clock ticks, so the block scales each value by five before it counts.

After a synchronous clear the block runs in free-running mode and repeats the waveform indefinitely. A one-cycle mode strobe moves it into burst mode, where it waits with the line held low. A one-cycle fire strobe then emits a programmed number of whole periods, with the busy flag high for exactly that stretch, and the block returns to waiting. Only a clear brings it back to free-running mode.

Period and width are taken into the generator only at the end of a period, or at the launch of a burst. Editing them never cuts short a pulse that is already in flight. All pins are plain control and status signals. There is no data stream, so there is no back-pressure.

Top module: `pulse_burst_gen`

## Requirements
- R1: While `clr_i` is high at a clock edge, the block resets. After that edge `pulse_o` and `busy_o` are 0 and the block is in free-running mode.
- R2: In free-running mode the period of `pulse_o` is 5·`period_i` cycles. The line is high for the first 5·`width_i` cycles of each period. The first high cycle follows the first edge after clear is released.
- R3: A period value of 0 or a width value of 0 keeps `pulse_o` at 0.
- R4: A nonzero width that is at least the period holds `pulse_o` at 1 for as long as the generator runs.
- R5: A new `period_i` or `width_i` takes effect only at the next period boundary. The period in progress keeps its old high and low lengths.
- R6: A high `mode_stb_i` in free-running mode selects burst mode. From the next cycle `pulse_o` and `busy_o` stay 0 until a burst is fired.
- R7: In burst mode, a high `fire_stb_i` with a nonzero `burst_cnt_i` N sets `busy_o` for exactly N·5·`period_i` cycles, starting the next cycle. During that time the block emits N pulses, each 5·`width_i` cycles long.
- R8: When a burst ends, `pulse_o` stays 0 and the block waits in burst mode. A later fire strobe launches a new burst with the values present at that time.
- R9: The block ignores a fire strobe in three cases: while a burst is busy, when the burst count is 0, and in free-running mode.
- R10: A clear during a burst aborts it and returns the block to free-running mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 50 MHz |
| clr_i | input | 1 | Synchronous clear, active high |
| period_i | input | 17 | Period in 0.1 µs steps |
| width_i | input | 17 | High time in 0.1 µs steps |
| burst_cnt_i | input | 8 | Number of pulses in one burst |
| mode_stb_i | input | 1 | One-cycle strobe selecting burst mode |
| fire_stb_i | input | 1 | One-cycle strobe launching a burst |
| pulse_o | output | 1 | Pulse train output |
| busy_o | output | 1 | High while a burst is being emitted |

## Verification
Free-running mode is tried with a narrow duty cycle and with a wide one. The measured high and low run lengths confirm both the ×5 scaling and the position of the high phase within each period. The degenerate patterns tell apart the handling of edge values: a zero width, a zero period, a width equal to the period and a width above it. Changing the inputs mid-pulse separates boundary-only sampling from immediate loading. In burst mode, three measurements over each burst pin down how many whole periods were emitted: busy cycles, high cycles and rising edges. The same three counts show whether the strobes that should be ignored were in fact ignored.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_BURST = 2'd2
  } gen_state_e;

endpackage

// File: rtl/pbg_scale.sv
module pbg_scale #(
  parameter int IN_W   = 17,
  parameter int FACTOR = 5,
  parameter int OUT_W  = IN_W + $clog2(FACTOR)
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] ticks_o
);

  localparam bit IS_POW2 = (FACTOR & (FACTOR - 1)) == 0;
  localparam int SHIFT   = $clog2(FACTOR);

  generate
    if (IS_POW2) begin : g_shift
      assign ticks_o = OUT_W'(val_i) << SHIFT;
    end else begin : g_mult
      assign ticks_o = OUT_W'(val_i) * OUT_W'(FACTOR);
    end
  endgenerate

endmodule

// File: rtl/pbg_phase_timer.sv
module pbg_phase_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] per_in_i,
  input  logic [CNT_W-1:0] wid_in_i,
  output logic             wrap_o,
  output logic             pulse_o,
  output logic [CNT_W-1:0] ph_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] wid_o
);

  logic [CNT_W-1:0] ph_q, per_q, wid_q;
  logic [CNT_W-1:0] ph_inc;
  logic             pulse_q;

  assign ph_inc = ph_q + CNT_W'(1);
  assign wrap_o = (per_q == '0) || (ph_q == per_q - CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      ph_q    <= '0;
      per_q   <= '0;
      wid_q   <= '0;
      pulse_q <= 1'b0;
    end else if (stop_i) begin
      ph_q    <= '0;
      pulse_q <= 1'b0;
    end else if (load_i) begin
      ph_q    <= '0;
      per_q   <= per_in_i;
      wid_q   <= wid_in_i;
      pulse_q <= (per_in_i != '0) && (wid_in_i != '0);
    end else begin
      ph_q    <= ph_inc;
      pulse_q <= ph_inc < wid_q;
    end
  end

  assign pulse_o = pulse_q;
  assign ph_o    = ph_q;
  assign per_o   = per_q;
  assign wid_o   = wid_q;

endmodule

// File: rtl/pbg_burst_ctrl.sv
module pbg_burst_ctrl
  import pbg_pkg::*;
#(
  parameter int BURST_W = 8
) (
  input  logic               clk_i,
  input  logic               clr_i,
  input  logic               mode_stb_i,
  input  logic               fire_stb_i,
  input  logic [BURST_W-1:0] burst_cnt_i,
  input  logic               wrap_i,
  output logic               stop_o,
  output logic               load_o,
  output logic               busy_o,
  output gen_state_e         st_o,
  output logic [BURST_W-1:0] rem_o
);

  gen_state_e         st_q;
  logic [BURST_W-1:0] rem_q;
  logic               start, last;

  assign start  = (st_q == ST_IDLE) && fire_stb_i && (burst_cnt_i != '0);
  assign last   = (st_q == ST_BURST) && wrap_i && (rem_q == BURST_W'(1));
  assign stop_o = ((st_q == ST_IDLE) && !start) || last ||
                  ((st_q == ST_FREE) && mode_stb_i);
  assign load_o = start || wrap_i;

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      st_q  <= ST_FREE;
      rem_q <= '0;
    end else begin
      unique case (st_q)
        ST_FREE: begin
          if (mode_stb_i) st_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_BURST;
            rem_q <= burst_cnt_i;
          end
        end
        ST_BURST: begin
          if (wrap_i) begin
            if (last) begin
              st_q  <= ST_IDLE;
              rem_q <= '0;
            end else begin
              rem_q <= rem_q - BURST_W'(1);
            end
          end
        end
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_BURST);
  assign st_o   = st_q;
  assign rem_o  = rem_q;

endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
  import pbg_pkg::*;
#(
  parameter int VAL_W   = 17,
  parameter int STEP_TK = 5,
  parameter int BURST_W = 8
) (
  input  logic               clk_i,
  input  logic               clr_i,
  input  logic [VAL_W-1:0]   period_i,
  input  logic [VAL_W-1:0]   width_i,
  input  logic [BURST_W-1:0] burst_cnt_i,
  input  logic               mode_stb_i,
  input  logic               fire_stb_i,
  output logic               pulse_o,
  output logic               busy_o
);

  localparam int CNT_W = VAL_W + $clog2(STEP_TK);

  logic [CNT_W-1:0]   per_ticks, wid_ticks;
  logic [CNT_W-1:0]   ph_w, per_w, wid_w;
  logic [BURST_W-1:0] rem_w;
  logic               wrap_w, stop_w, load_w;
  gen_state_e         st_w;

  pbg_scale #(.IN_W(VAL_W), .FACTOR(STEP_TK), .OUT_W(CNT_W)) u_scale_per (
    .val_i(period_i), .ticks_o(per_ticks)
  );

  pbg_scale #(.IN_W(VAL_W), .FACTOR(STEP_TK), .OUT_W(CNT_W)) u_scale_wid (
    .val_i(width_i), .ticks_o(wid_ticks)
  );

  pbg_burst_ctrl #(.BURST_W(BURST_W)) u_ctrl (
    .clk_i       (clk_i),
    .clr_i       (clr_i),
    .mode_stb_i  (mode_stb_i),
    .fire_stb_i  (fire_stb_i),
    .burst_cnt_i (burst_cnt_i),
    .wrap_i      (wrap_w),
    .stop_o      (stop_w),
    .load_o      (load_w),
    .busy_o      (busy_o),
    .st_o        (st_w),
    .rem_o       (rem_w)
  );

  pbg_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .clr_i    (clr_i),
    .stop_i   (stop_w),
    .load_i   (load_w),
    .per_in_i (per_ticks),
    .wid_in_i (wid_ticks),
    .wrap_o   (wrap_w),
    .pulse_o  (pulse_o),
    .ph_o     (ph_w),
    .per_o    (per_w),
    .wid_o    (wid_w)
  );

endmodule

// File: rtl/pulse_burst_gen_chk.sv
module pulse_burst_gen_chk
  import pbg_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int BURST_W = 8
) (
  input  logic               clk_i,
  input  logic               clr_i,
  input  logic               fire_stb_i,
  input  logic               pulse_o,
  input  logic               busy_o,
  input  gen_state_e         st_w,
  input  logic               wrap_w,
  input  logic [CNT_W-1:0]   ph_w,
  input  logic [CNT_W-1:0]   per_w,
  input  logic [CNT_W-1:0]   wid_w,
  input  logic [BURST_W-1:0] rem_w
);

  a_r1_clear_quiet: assert property (@(posedge clk_i) disable iff (clr_i)
    $past(clr_i) |-> (!pulse_o && !busy_o && st_w == ST_FREE));

  a_r2_phase_bound: assert property (@(posedge clk_i) disable iff (clr_i)
    (per_w != '0) |-> (ph_w < per_w));

  a_r3_zero_width_low: assert property (@(posedge clk_i) disable iff (clr_i)
    (wid_w == '0) |-> !pulse_o);

  a_r4_wide_high: assert property (@(posedge clk_i) disable iff (clr_i)
    (st_w != ST_IDLE && per_w != '0 && wid_w >= per_w) |-> pulse_o);

  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (clr_i)
    (st_w == ST_IDLE) |-> (!pulse_o && !busy_o));

  a_r7_busy_from_fire: assert property (@(posedge clk_i) disable iff (clr_i)
    $rose(busy_o) |-> $past(fire_stb_i));

  a_r7_rem_nonzero: assert property (@(posedge clk_i) disable iff (clr_i)
    (st_w == ST_BURST) |-> (rem_w != '0));

  a_r9_rem_stable: assert property (@(posedge clk_i) disable iff (clr_i)
    (st_w == ST_BURST && !wrap_w) |=> $stable(rem_w));

endmodule

bind pulse_burst_gen pulse_burst_gen_chk #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_chk (
  .clk_i      (clk_i),
  .clr_i      (clr_i),
  .fire_stb_i (fire_stb_i),
  .pulse_o    (pulse_o),
  .busy_o     (busy_o),
  .st_w       (st_w),
  .wrap_w     (wrap_w),
  .ph_w       (ph_w),
  .per_w      (per_w),
  .wid_w      (wid_w),
  .rem_w      (rem_w)
);

// File: tb/pulse_burst_gen_tb.sv
`timescale 1ns/1ps
module pulse_burst_gen_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [16:0] period = '0;
  logic [16:0] width  = '0;
  logic [7:0]  bcnt   = '0;
  logic        mode_stb = 1'b0;
  logic        fire_stb = 1'b0;
  logic        pulse, busy;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_burst_gen dut_i (
    .clk_i(clk), .clr_i(clr), .period_i(period), .width_i(width),
    .burst_cnt_i(bcnt), .mode_stb_i(mode_stb), .fire_stb_i(fire_stb),
    .pulse_o(pulse), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    chk("R1 pulse after clear", int'(pulse), 0);
    chk("R1 busy after clear", int'(busy), 0);
    clr = 1'b0;
  endtask

  task automatic wait_rise();
    bit prev = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pulse && !prev) return;
      prev = pulse;
    end
  endtask

  task automatic measure_runs(output int hi, output int lo);
    hi = 1; lo = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!pulse) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pulse) break;
      lo++;
    end
  endtask

  task automatic count_window(input int len, output int hi, output int bz, output int rises);
    bit prev = 1'b0;
    hi = 0; bz = 0; rises = 0;
    for (int i = 0; i < len; i++) begin
      if (i != 0) @(negedge clk);
      hi += int'(pulse);
      bz += int'(busy);
      if (pulse && !prev) rises++;
      prev = pulse;
    end
  endtask

  task automatic strobe_fire();
    fire_stb = 1'b1;
    @(negedge clk);
    fire_stb = 1'b0;
  endtask

  task automatic test_free_run();
    int hi, lo;
    period = 17'd6; width = 17'd2;
    do_clear();
    @(negedge clk);
    chk("R2 first high one cycle after release", int'(pulse), 1);
    wait_rise();
    measure_runs(hi, lo);
    chk("R2 high length 5*2", hi, 10);
    chk("R2 low length 5*(6-2)", lo, 20);
    period = 17'd3; width = 17'd2;
    wait_rise();
    wait_rise();
    measure_runs(hi, lo);
    chk("R2 wide duty high 5*2", hi, 10);
    chk("R2 wide duty low 5*1", lo, 5);
  endtask

  task automatic test_degenerate();
    int hi, bz, rs;
    period = 17'd4; width = 17'd0;
    repeat (45) @(negedge clk);
    count_window(60, hi, bz, rs);
    chk("R3 zero width stays low", hi, 0);
    period = 17'd0; width = 17'd3;
    repeat (45) @(negedge clk);
    count_window(60, hi, bz, rs);
    chk("R3 zero period stays low", hi, 0);
    period = 17'd3; width = 17'd3;
    repeat (5) @(negedge clk);
    count_window(40, hi, bz, rs);
    chk("R4 width equal period constant high", hi, 40);
    period = 17'd2; width = 17'd5;
    repeat (20) @(negedge clk);
    count_window(40, hi, bz, rs);
    chk("R4 width above period constant high", hi, 40);
  endtask

  task automatic test_boundary_sample();
    int hi, lo;
    period = 17'd4; width = 17'd2;
    do_clear();
    wait_rise();
    hi = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (hi == 3) begin period = 17'd6; width = 17'd5; end
      if (!pulse) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pulse) break;
      lo++;
    end
    chk("R5 current high kept", hi, 10);
    chk("R5 current low kept", lo, 10);
    measure_runs(hi, lo);
    chk("R5 new high applied", hi, 25);
    chk("R5 new low applied", lo, 5);
  endtask

  task automatic test_fire_in_free();
    int hi, bz, rs;
    period = 17'd4; width = 17'd2; bcnt = 8'd3;
    do_clear();
    fire_stb = 1'b1;
    count_window(60, hi, bz, rs);
    fire_stb = 1'b0;
    chk("R9 fire ignored in free mode busy", bz, 0);
    chk("R9 fire ignored in free mode highs", hi, 30);
  endtask

  task automatic test_enter_burst();
    int hi, bz, rs;
    mode_stb = 1'b1;
    @(negedge clk);
    mode_stb = 1'b0;
    chk("R6 pulse low after mode select", int'(pulse), 0);
    count_window(50, hi, bz, rs);
    chk("R6 waiting line low", hi, 0);
    chk("R6 waiting not busy", bz, 0);
  endtask

  task automatic test_burst_basic();
    int hi, bz, rs;
    period = 17'd4; width = 17'd1; bcnt = 8'd3;
    strobe_fire();
    chk("R7 busy right after fire", int'(busy), 1);
    count_window(100, hi, bz, rs);
    chk("R7 busy cycles 3*20", bz, 60);
    chk("R7 high cycles 3*5", hi, 15);
    chk("R7 pulse count", rs, 3);
    period = 17'd2; width = 17'd1; bcnt = 8'd1;
    strobe_fire();
    count_window(40, hi, bz, rs);
    chk("R8 rearmed burst busy 10", bz, 10);
    chk("R8 rearmed burst highs 5", hi, 5);
    chk("R8 rearmed burst one pulse", rs, 1);
  endtask

  task automatic test_burst_ignored();
    int hi, bz, rs;
    bit prev;
    period = 17'd4; width = 17'd2; bcnt = 8'd2;
    strobe_fire();
    hi = 0; bz = 0; rs = 0; prev = 1'b0;
    for (int i = 0; i < 80; i++) begin
      if (i != 0) @(negedge clk);
      if (i == 8) fire_stb = 1'b1;
      if (i == 9) fire_stb = 1'b0;
      hi += int'(pulse); bz += int'(busy);
      if (pulse && !prev) rs++;
      prev = pulse;
    end
    chk("R9 fire while busy no extension", bz, 40);
    chk("R9 fire while busy pulse count", rs, 2);
    bcnt = 8'd0;
    strobe_fire();
    count_window(40, hi, bz, rs);
    chk("R9 zero count no busy", bz, 0);
    chk("R9 zero count no pulse", hi, 0);
  endtask

  task automatic test_clear_abort();
    int hi, bz, rs;
    period = 17'd4; width = 17'd2; bcnt = 8'd5;
    strobe_fire();
    repeat (10) @(negedge clk);
    chk("R10 busy before abort", int'(busy), 1);
    do_clear();
    count_window(60, hi, bz, rs);
    chk("R10 free mode after abort busy", bz, 0);
    chk("R10 free mode after abort highs", hi, 30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_free_run();
    test_degenerate();
    test_boundary_sample();
    test_fire_in_free();
    test_enter_burst();
    test_burst_basic();
    test_burst_ignored();
    test_clear_abort();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait (cyc >= WDOG_LIMIT);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule